// File: doc/BRIEF.md
# Oscillator Frequency-Lock Controller

This block trims a digitally controlled oscillator until the number of oscillator cycles that fit in one period of a slow reference matches a target. It runs entirely in the oscillator clock domain. A free-running counter advances on every oscillator cycle. The reference input passes through a two-flop synchronizer, and each rising edge of the synchronized reference captures the counter. The difference from the previous capture gives the measured period in oscillator cycles.

After each capture the block compares the measured count with the target and moves the tuning word by one step. The tuning word is built from an 8-bit fine code below a 3-bit range code. A measurement below the target raises the word and a measurement above it lowers the word. An overflow of the fine code carries into the range code, and a decrement that reaches a fine code of zero borrows from the range code. Locking ends on an exact match, or when the range code cannot move any further in the requested direction. The block then raises `done` and halts its counter and capture logic.

In normal use the reference is a 32768 Hz clock divided by 8, and the target is 625. With those values the loop settles the oscillator at 2.56 MHz. The oscillator itself sits outside the block. It takes `tune_word` as its control input and clocks the block through `clk`.

Top module: `dco_freq_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is: `tune_word` equal to {RANGE_RST, FINE_RST} (range in bits 10:8, fine in bits 7:0), `busy` low and `done` low.
- R2: A `start` pulse sets `busy` high and `done` low on the following edge, and clears both the cycle counter and the previous capture to zero. While `busy` is low, reference edges leave `tune_word` unchanged.
- R3: Each synchronized rising edge of `ref_in` while busy captures the counter. The measured count is the capture minus the previous capture, modulo 2^16, and exactly one tuning step is applied per capture.
- R4: A count below `target_count` increments the fine code by one.
- R5: A count above `target_count` decrements the fine code by one. A decrement from 0 wraps to 255 and tuning continues.
- R6: When an increment wraps the fine code from 255 to 0 and the range code is below 7, the range code increases by one.
- R7: When an increment wraps the fine code from 255 to 0 and the range code is 7, the fine code becomes 0, the range code stays at 7, and locking ends with `done` high and `busy` low.
- R8: When a decrement takes the fine code from 1 to 0 and the range code is above 0, the range code decreases by one and the fine code stays at 0.
- R9: When a decrement takes the fine code from 1 to 0 and the range code is 0, locking ends with `tune_word` equal to 0, `done` high and `busy` low.
- R10: A count equal to `target_count` ends locking with `tune_word` unchanged, `done` high and `busy` low.
- R11: After locking ends, `tune_word` and `done` hold their values and reference edges are ignored until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a lock attempt |
| ref_in | input | 1 | Asynchronous reference clock |
| target_count | input | 16 | Wanted oscillator cycles per reference period |
| tune_word | output | 11 | Range code in bits 10:8, fine code in bits 7:0 |
| busy | output | 1 | Locking in progress |
| done | output | 1 | Locking finished (match or range limit) |

## Verification
The bench builds two copies of the block that share the reference. The first copy has the range reset value set to 6 and the fine reset value set to 254. With those settings, a short run of too-fast reference periods reaches the carry into range 7 and then the upper saturation stop. The second copy starts at range 1 and fine 2, so a few too-slow periods reach the borrow into range 0, and a further 256 reach the lower saturation stop. A target of 40 is applied to both, which keeps each reference period short enough that several hundred steps finish well inside the run length. Exact-match stopping is checked by restarting the first copy with the reference period set equal to the target.

// File: rtl/dco_lock_pkg.sv
package dco_lock_pkg;

    // Direction chosen by the comparison of measured count and target
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign rise = pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             capture,
    output logic [CNT_W-1:0] period
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prev;
    } meter_t;

    meter_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear) begin
            nxt_d.cnt  = '0;
            nxt_d.prev = '0;
        end else if (run) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
            if (capture) nxt_d.prev = cur_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    // Modular difference between the live counter and the last capture
    assign period = cur_q.cnt - cur_q.prev;
endmodule

// File: rtl/tune_stepper.sv
module tune_stepper
    import dco_lock_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int FINE_W  = 8,
    parameter int RANGE_W = 3
) (
    input  logic [CNT_W-1:0]   period,
    input  logic [CNT_W-1:0]   target,
    input  logic [FINE_W-1:0]  fine_cur,
    input  logic [RANGE_W-1:0] range_cur,
    output logic [FINE_W-1:0]  fine_nxt,
    output logic [RANGE_W-1:0] range_nxt,
    output logic               finish
);
    localparam logic [FINE_W-1:0]  FINE_TOP  = {FINE_W{1'b1}};
    localparam logic [RANGE_W-1:0] RANGE_TOP = {RANGE_W{1'b1}};
    localparam logic [FINE_W-1:0]  FINE_ONE  = {{(FINE_W-1){1'b0}}, 1'b1};

    step_dir_e dir;

    always_comb begin
        if (period == target)     dir = DIR_HOLD;
        else if (period < target) dir = DIR_UP;
        else                      dir = DIR_DOWN;
    end

    always_comb begin
        fine_nxt  = fine_cur;
        range_nxt = range_cur;
        finish    = 1'b0;
        unique case (dir)
            DIR_HOLD: finish = 1'b1;
            DIR_UP: begin
                fine_nxt = fine_cur + 1'b1;
                if (fine_cur == FINE_TOP) begin
                    if (range_cur == RANGE_TOP) finish = 1'b1;
                    else range_nxt = range_cur + 1'b1;
                end
            end
            DIR_DOWN: begin
                fine_nxt = fine_cur - 1'b1;
                if (fine_cur == FINE_ONE) begin
                    if (range_cur == '0) finish = 1'b1;
                    else range_nxt = range_cur - 1'b1;
                end
            end
            default: finish = 1'b0;
        endcase
    end
endmodule

// File: rtl/dco_freq_lock.sv
module dco_freq_lock #(
    parameter int CNT_W       = 16,
    parameter int FINE_W      = 8,
    parameter int RANGE_W     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int FINE_RST    = 96,
    parameter int RANGE_RST   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       ref_in,
    input  logic [CNT_W-1:0]           target_count,
    output logic [RANGE_W+FINE_W-1:0]  tune_word,
    output logic                       busy,
    output logic                       done
);
    localparam logic [FINE_W-1:0]  FINE_INIT  = FINE_W'(FINE_RST);
    localparam logic [RANGE_W-1:0] RANGE_INIT = RANGE_W'(RANGE_RST);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [RANGE_W-1:0] range;
        logic [FINE_W-1:0]  fine;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic               ref_rise;
    logic [CNT_W-1:0]   period;
    logic [FINE_W-1:0]  fine_step;
    logic [RANGE_W-1:0] range_step;
    logic               step_finish;

    ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_in),
        .rise     (ref_rise)
    );

    period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .run     (cur_q.busy),
        .capture (cur_q.busy & ref_rise),
        .period  (period)
    );

    tune_stepper #(.CNT_W(CNT_W), .FINE_W(FINE_W), .RANGE_W(RANGE_W)) u_step (
        .period    (period),
        .target    (target_count),
        .fine_cur  (cur_q.fine),
        .range_cur (cur_q.range),
        .fine_nxt  (fine_step),
        .range_nxt (range_step),
        .finish    (step_finish)
    );

    always_comb begin
        nxt_d = cur_q;
        if (start) begin
            nxt_d.busy = 1'b1;
            nxt_d.done = 1'b0;
        end else if (cur_q.busy && ref_rise) begin
            nxt_d.fine  = fine_step;
            nxt_d.range = range_step;
            if (step_finish) begin
                nxt_d.busy = 1'b0;
                nxt_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.busy  <= 1'b0;
            cur_q.done  <= 1'b0;
            cur_q.range <= RANGE_INIT;
            cur_q.fine  <= FINE_INIT;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tune_word = {cur_q.range, cur_q.fine};
    assign busy      = cur_q.busy;
    assign done      = cur_q.done;
endmodule

// File: rtl/dco_freq_lock_chk.sv
module dco_freq_lock_chk #(
    parameter int FINE_W    = 8,
    parameter int RANGE_W   = 3,
    parameter int FINE_RST  = 96,
    parameter int RANGE_RST = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic [RANGE_W+FINE_W-1:0] tune_word,
    input logic                      busy,
    input logic                      done
);
    localparam logic [RANGE_W+FINE_W-1:0] WORD_INIT =
        {RANGE_W'(RANGE_RST), FINE_W'(FINE_RST)};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (tune_word == WORD_INIT && !busy && !done));

    // R2
    start_arms_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(tune_word) && $stable(done));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=>
            (tune_word[FINE_W-1:0] == $past(tune_word[FINE_W-1:0]))
         || (tune_word[FINE_W-1:0] == FINE_W'($past(tune_word[FINE_W-1:0]) + 1'b1))
         || (tune_word[FINE_W-1:0] == FINE_W'($past(tune_word[FINE_W-1:0]) - 1'b1)));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R10
    done_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));
endmodule

bind dco_freq_lock dco_freq_lock_chk #(
    .FINE_W    (FINE_W),
    .RANGE_W   (RANGE_W),
    .FINE_RST  (FINE_RST),
    .RANGE_RST (RANGE_RST)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tune_word (tune_word),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_dco_freq_lock.sv
`timescale 1ns/1ps
module tb_dco_freq_lock;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0;
    logic        start_a = 1'b0;
    logic        start_b = 1'b0;
    logic [15:0] target = 16'd40;
    logic [10:0] word_a, word_b;
    logic        busy_a, busy_b, done_a, done_b;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dco_freq_lock #(.FINE_RST(254), .RANGE_RST(6)) dut (
        .clk(clk), .rst(rst), .start(start_a), .ref_in(ref_in),
        .target_count(target), .tune_word(word_a), .busy(busy_a), .done(done_a)
    );

    dco_freq_lock #(.FINE_RST(2), .RANGE_RST(1)) dut_lo (
        .clk(clk), .rst(rst), .start(start_b), .ref_in(ref_in),
        .target_count(target), .tune_word(word_b), .busy(busy_b), .done(done_b)
    );

    function automatic logic [10:0] tw(input int rng, input int fn);
        return {3'(rng), 8'(fn)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ref_pulse(input int p);
        ref_in = 1'b1;
        repeat (p / 2) @(negedge clk);
        ref_in = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    task automatic pulse_start_a();
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
    endtask

    task automatic pulse_start_b();
        start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0;
    endtask

    task automatic test_reset();
        chk(word_a == tw(6, 254), "R1 word_a", word_a, tw(6, 254));
        chk(word_b == tw(1, 2),   "R1 word_b", word_b, tw(1, 2));
        chk(!busy_a && !done_a,   "R1 flags", {busy_a, done_a}, 0);
    endtask

    task automatic test_idle_ignored();
        ref_pulse(30);
        ref_pulse(30);
        chk(word_a == tw(6, 254), "R2 idle word", word_a, tw(6, 254));
        chk(!busy_a, "R2 idle busy", busy_a, 0);
    endtask

    task automatic test_carry_and_top();
        pulse_start_a();
        chk(busy_a && !done_a, "R2 armed", {busy_a, done_a}, 2);
        ref_pulse(30);   // first capture: small count, one step up
        chk(word_a == tw(6, 255), "R3 R4 first step", word_a, tw(6, 255));
        ref_pulse(30);
        chk(word_a == tw(7, 0), "R6 carry", word_a, tw(7, 0));
        for (int i = 0; i < 255; i++) ref_pulse(30);
        chk(word_a == tw(7, 255), "R4 climb", word_a, tw(7, 255));
        chk(busy_a, "R4 still busy", busy_a, 1);
        ref_pulse(30);
        chk(word_a == tw(7, 0), "R7 top word", word_a, tw(7, 0));
        chk(done_a && !busy_a, "R7 flags", {busy_a, done_a}, 1);
        chk(word_b == tw(1, 2), "R2 other idle", word_b, tw(1, 2));
    endtask

    task automatic test_borrow_and_bottom();
        pulse_start_b();
        ref_pulse(50);   // first capture: small count, one step up
        chk(word_b == tw(1, 3), "R4 lo first", word_b, tw(1, 3));
        ref_pulse(50);
        chk(word_b == tw(1, 2), "R5 down", word_b, tw(1, 2));
        ref_pulse(50);
        ref_pulse(50);
        chk(word_b == tw(0, 0), "R8 borrow", word_b, tw(0, 0));
        ref_pulse(50);
        chk(word_b == tw(0, 255), "R5 wrap continue", word_b, tw(0, 255));
        chk(busy_b, "R5 busy", busy_b, 1);
        for (int i = 0; i < 255; i++) ref_pulse(50);
        chk(word_b == tw(0, 0), "R9 bottom word", word_b, tw(0, 0));
        chk(done_b && !busy_b, "R9 flags", {busy_b, done_b}, 1);
        chk(word_a == tw(7, 0) && done_a, "R11 held", word_a, tw(7, 0));
    endtask

    task automatic test_match();
        pulse_start_a();
        chk(!done_a && busy_a, "R2 restart", {busy_a, done_a}, 2);
        ref_pulse(40);
        chk(word_a == tw(7, 1), "R4 no carry", word_a, tw(7, 1));
        ref_pulse(40);
        chk(word_a == tw(7, 1), "R10 match word", word_a, tw(7, 1));
        chk(done_a && !busy_a, "R10 flags", {busy_a, done_a}, 1);
        ref_pulse(25);
        ref_pulse(25);
        chk(word_a == tw(7, 1) && done_a, "R11 ignored", word_a, tw(7, 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_idle_ignored();
        test_carry_and_top();
        test_borrow_and_bottom();
        test_match();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule